// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first keeps a table of 2-bit saturating counters indexed only by low bits of the branch address. The second is a correlating predictor. It indexes a table of counters with the outcomes of the most recent resolved branches joined to the same address bits. A third table of 2-bit chooser counters, indexed by address, learns for each branch which component has been more reliable. It then picks that component's guess.

A fetch stage presents a branch address on the lookup port and receives the prediction combinationally in the same cycle. Both component guesses and the chooser decision are also visible on the port. When the branch resolves, the execute stage presents its address and actual direction on the update port. All three tables and the global outcome history are trained on the next clock edge. All sizes are parameters.

Top module: `tourney_predictor`

## Requirements
- R1: While `rst` is high at a rising edge, every local and global counter is set to the weakly not-taken value (binary 01 for 2-bit counters), every chooser counter is set to 01 (weakly favour local), and `hist` is cleared to 0. After reset, every lookup therefore predicts not-taken.
- R2: On each edge with `up_valid` high, `hist` shifts left by one and takes `up_taken` (1 = taken) into bit 0, keeping only the last `HIST_M` outcomes.
- R3: `pred_local` is the MSB of the local counter at index `lk_pc[IDX_W+1:2]`. On an update, the local counter at index `up_pc[IDX_W+1:2]` counts up on taken and down on not-taken. It saturates at 0 and at 2^CNT_N−1.
- R4: `pred_global` is the MSB of the global counter at index {`hist`, `lk_pc[IDX_W+1:2]`}, with `hist` in the upper bits. On an update, the global counter at {`hist`, `up_pc[IDX_W+1:2]`} is trained the same way, using `hist` as it stood before that edge's shift.
- R5: `sel_global` is the MSB of the chooser counter at the lookup address, and `pred_taken` equals `pred_global` when it is 1 and `pred_local` otherwise. On an update, the chooser counts up when only the global guess matched the outcome and down when only the local guess matched. In all other cases it is left unchanged. It saturates at 0 and 3.
- R6: While `lk_valid` is low, `pred_taken`, `pred_local`, `pred_global` and `sel_global` are all 0.
- R7: An update changes lookups only from the next cycle on. A lookup in the same cycle as an update to the same entry sees the old counter values.
- R8: A counter that has saturated at the taken end keeps predicting taken after one not-taken outcome, and predicts not-taken only after a second consecutive one.
- R9: While `up_valid` is low, no counter and no history bit changes, whatever `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final prediction, 1 = taken |
| pred_local | output | 1 | Guess of the address-indexed component |
| pred_global | output | 1 | Guess of the history-correlated component |
| sel_global | output | 1 | 1 when the chooser picks the global component |
| hist | output | HIST_M | Global outcome history, newest outcome in bit 0 |
| up_valid | input | 1 | Resolved branch update valid |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |

## Verification
The checker assumes that `lk_valid`, `lk_pc`, `up_valid`, `up_pc` and `up_taken` carry known values at every sampled edge once reset has been released. Its lookup-stability property also assumes that an unchanged lookup address with no update in between must read an unchanged local counter. The bench meets these assumptions by driving every input from a task on the falling edge, holding each value for a whole cycle, and never leaving a port undriven. The stimulus mixes directed runs (saturation, back-to-back opposite outcomes, same-cycle update and lookup, idle updates) with a long run of outcomes that depend on the history. The history-dependent outcomes drive the chooser toward the global component for some branches and leave others on the local one.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] chooser_t;

  localparam chooser_t CHOOSER_INIT = 2'b01;

  function automatic chooser_t chooser_step(input chooser_t cur,
                                            input logic     local_ok,
                                            input logic     global_ok);
    chooser_t nxt;
    nxt = cur;
    if (global_ok && !local_ok && cur != 2'b11) nxt = cur + 2'd1;
    else if (local_ok && !global_ok && cur != 2'b00) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tbp_sat_step.sv
module tbp_sat_step #(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         inc,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    if (inc) nxt = (cur == TOP) ? cur : cur + 1'b1;
    else     nxt = (cur == '0)  ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int          AW   = 4,
  parameter int          W    = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_idx,
  output logic [W-1:0]  ra_dat,
  input  logic [AW-1:0] rb_idx,
  output logic [W-1:0]  rb_dat,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_dat
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (we) begin
      mem[wr_idx] <= wr_dat;
    end
  end

  assign ra_dat = mem[ra_idx];
  assign rb_dat = mem[rb_idx];
endmodule

// File: rtl/tbp_hist_reg.sv
module tbp_hist_reg #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         bit_in,
  output logic [M-1:0] q
);
  logic [M:0] widened;

  assign widened = {q, bit_in};

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= widened[M-1:0];
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W   = 16,
  parameter int IDX_W  = 4,
  parameter int HIST_M = 2,
  parameter int CNT_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_taken,
  output logic              pred_local,
  output logic              pred_global,
  output logic              sel_global,
  output logic [HIST_M-1:0] hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken
);
  import tbp_pkg::*;

  localparam int G_AW = IDX_W + HIST_M;
  localparam logic [CNT_N-1:0] CTR_INIT = {1'b0, {(CNT_N-1){1'b1}}};

  logic [IDX_W-1:0] lk_li, up_li;
  logic [G_AW-1:0]  lk_gi, up_gi;

  assign lk_li = lk_pc[IDX_W+1:2];
  assign up_li = up_pc[IDX_W+1:2];
  assign lk_gi = {hist, lk_li};
  assign up_gi = {hist, up_li};

  logic [CNT_N-1:0] loc_lk, loc_up, loc_nxt;
  logic [CNT_N-1:0] glb_lk, glb_up, glb_nxt;
  chooser_t         cho_lk, cho_up, cho_nxt;

  tbp_ctr_table #(.AW(IDX_W), .W(CNT_N), .INIT(CTR_INIT)) u_local (
    .clk(clk), .rst(rst),
    .ra_idx(lk_li), .ra_dat(loc_lk),
    .rb_idx(up_li), .rb_dat(loc_up),
    .we(up_valid), .wr_idx(up_li), .wr_dat(loc_nxt)
  );

  tbp_ctr_table #(.AW(G_AW), .W(CNT_N), .INIT(CTR_INIT)) u_global (
    .clk(clk), .rst(rst),
    .ra_idx(lk_gi), .ra_dat(glb_lk),
    .rb_idx(up_gi), .rb_dat(glb_up),
    .we(up_valid), .wr_idx(up_gi), .wr_dat(glb_nxt)
  );

  tbp_ctr_table #(.AW(IDX_W), .W(2), .INIT(CHOOSER_INIT)) u_chooser (
    .clk(clk), .rst(rst),
    .ra_idx(lk_li), .ra_dat(cho_lk),
    .rb_idx(up_li), .rb_dat(cho_up),
    .we(up_valid), .wr_idx(up_li), .wr_dat(cho_nxt)
  );

  tbp_sat_step #(.W(CNT_N)) u_loc_step (.cur(loc_up), .inc(up_taken), .nxt(loc_nxt));
  tbp_sat_step #(.W(CNT_N)) u_glb_step (.cur(glb_up), .inc(up_taken), .nxt(glb_nxt));

  logic loc_ok, glb_ok;
  assign loc_ok  = (loc_up[CNT_N-1] == up_taken);
  assign glb_ok  = (glb_up[CNT_N-1] == up_taken);
  assign cho_nxt = chooser_step(cho_up, loc_ok, glb_ok);

  tbp_hist_reg #(.M(HIST_M)) u_hist (
    .clk(clk), .rst(rst), .shift(up_valid), .bit_in(up_taken), .q(hist)
  );

  assign pred_local  = lk_valid & loc_lk[CNT_N-1];
  assign pred_global = lk_valid & glb_lk[CNT_N-1];
  assign sel_global  = lk_valid & cho_lk[1];
  assign pred_taken  = sel_global ? pred_global : pred_local;
endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
  parameter int PC_W   = 16,
  parameter int IDX_W  = 4,
  parameter int HIST_M = 2,
  parameter int CNT_N  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [PC_W-1:0]   lk_pc,
  input logic              pred_taken,
  input logic              pred_local,
  input logic              pred_global,
  input logic              sel_global,
  input logic [HIST_M-1:0] hist,
  input logic              up_valid,
  input logic [PC_W-1:0]   up_pc,
  input logic              up_taken
);
  logic [HIST_M:0] hist_shifted;
  assign hist_shifted = {hist, up_taken};

  // R1: history is empty right after reset
  a_r1_hist_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hist == '0);

  // R2: update shifts the outcome into the history
  a_r2_hist_shift: assert property (@(posedge clk) disable iff (rst)
    ($past(up_valid) && !$past(rst)) |-> hist == $past(hist_shifted[HIST_M-1:0]));

  // R9: no update, no history change
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(up_valid) && !$past(rst)) |-> $stable(hist));

  // R5: final prediction follows the chooser
  a_r5_select: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> pred_taken == (sel_global ? pred_global : pred_local));

  // R6: idle lookup port drives zeros
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !pred_taken && !pred_local && !pred_global && !sel_global);

  // R3: same address, no update in between -> same local guess
  a_r3_local_stable: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(lk_valid) && !$past(up_valid) && !$past(rst) &&
     lk_pc == $past(lk_pc)) |-> $stable(pred_local));
endmodule

bind tourney_predictor tourney_predictor_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .HIST_M(HIST_M), .CNT_N(CNT_N)
) u_chk (.*);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;
  localparam int PC_W   = 16;
  localparam int IDX_W  = 4;
  localparam int HIST_M = 2;
  localparam int CNT_N  = 2;
  localparam int LN     = 1 << IDX_W;
  localparam int GN     = 1 << (IDX_W + HIST_M);
  localparam int CMAX   = (1 << CNT_N) - 1;
  localparam int HALF   = 1 << (CNT_N - 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [PC_W-1:0]   lk_pc = '0;
  logic              pred_taken, pred_local, pred_global, sel_global;
  logic [HIST_M-1:0] hist;
  logic              up_valid = 1'b0;
  logic [PC_W-1:0]   up_pc = '0;
  logic              up_taken = 1'b0;

  always #4 clk = ~clk;

  tourney_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_M(HIST_M), .CNT_N(CNT_N)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .sel_global(sel_global), .hist(hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  int n_chk = 0;
  int n_fail = 0;
  int m_loc [LN];
  int m_glb [GN];
  int m_cho [LN];
  int m_hist;
  int last_pt, last_pl, last_pg, last_sel, last_hist;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int li_of(input int pc);
    return (pc >> 2) & (LN - 1);
  endfunction

  function automatic int gi_of(input int pc, input int h);
    return (h << IDX_W) | li_of(pc);
  endfunction

  function automatic int sat(input int c, input int inc, input int top);
    if (inc != 0) return (c == top) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LN; i++) begin m_loc[i] = HALF - 1; m_cho[i] = 1; end
    for (int i = 0; i < GN; i++) m_glb[i] = HALF - 1;
    m_hist = 0;
  endtask

  // one clock cycle, starting and ending at a falling edge
  task automatic cycle(input int lkv, input int lkp, input int upv, input int upp, input int upt);
    int li, gi, ep_l, ep_g, ep_s, ep_t, lok, gok;
    lk_valid = lkv[0]; lk_pc = lkp[PC_W-1:0];
    up_valid = upv[0]; up_pc = upp[PC_W-1:0]; up_taken = upt[0];
    #1;
    li = li_of(lkp); gi = gi_of(lkp, m_hist);
    ep_l = (lkv != 0 && m_loc[li] >= HALF) ? 1 : 0;
    ep_g = (lkv != 0 && m_glb[gi] >= HALF) ? 1 : 0;
    ep_s = (lkv != 0 && m_cho[li] >= 2) ? 1 : 0;
    ep_t = ep_s != 0 ? ep_g : ep_l;
    last_pt = int'(pred_taken); last_pl = int'(pred_local);
    last_pg = int'(pred_global); last_sel = int'(sel_global); last_hist = int'(hist);
    check("R3", "pred_local", last_pl, ep_l);
    check("R4", "pred_global", last_pg, ep_g);
    check("R5", "sel_global", last_sel, ep_s);
    check(lkv != 0 ? "R5" : "R6", "pred_taken", last_pt, ep_t);
    check("R2", "hist", last_hist, m_hist);
    @(posedge clk);
    if (upv != 0) begin
      li = li_of(upp); gi = gi_of(upp, m_hist);
      lok = ((m_loc[li] >= HALF ? 1 : 0) == upt) ? 1 : 0;
      gok = ((m_glb[gi] >= HALF ? 1 : 0) == upt) ? 1 : 0;
      if (gok != 0 && lok == 0) m_cho[li] = sat(m_cho[li], 1, 3);
      else if (lok != 0 && gok == 0) m_cho[li] = sat(m_cho[li], 0, 3);
      m_loc[li] = sat(m_loc[li], upt, CMAX);
      m_glb[gi] = sat(m_glb[gi], upt, CMAX);
      m_hist = ((m_hist << 1) | upt) & ((1 << HIST_M) - 1);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h0, pc, tk, k;
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: fresh state predicts not-taken everywhere
    for (int p = 0; p < 4; p++) begin
      cycle(1, p * 52, 0, 0, 0);
      check("R1", "pred_taken after reset", last_pt, 0);
      check("R1", "hist after reset", last_hist, 0);
    end

    // R8: saturate taken, then two not-taken outcomes
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 'h10, 1);
    cycle(1, 'h10, 0, 0, 0);
    check("R8", "local after saturating taken", last_pl, 1);
    cycle(0, 0, 1, 'h10, 0);
    cycle(1, 'h10, 0, 0, 0);
    check("R8", "local after one not-taken", last_pl, 1);
    cycle(0, 0, 1, 'h10, 0);
    cycle(1, 'h10, 0, 0, 0);
    check("R8", "local after two not-taken", last_pl, 0);

    // R7: update and lookup same entry in the same cycle
    cycle(1, 'h24, 1, 'h24, 1);
    check("R7", "same-cycle lookup sees old", last_pl, 0);
    cycle(1, 'h24, 0, 0, 0);
    check("R7", "lookup after update edge", last_pl, 1);

    // R9: idle update port with noisy contents
    h0 = m_hist;
    for (int i = 0; i < 6; i++) cycle(1, 'h24, 0, i * 4, i & 1);
    check("R9", "hist unchanged while idle", last_hist, h0);
    check("R9", "local unchanged while idle", last_pl, 1);

    // R6: lookup port idle
    cycle(0, 'h24, 0, 0, 0);
    check("R6", "pred_local while idle", last_pl, 0);

    // long mixed run: outcomes correlated with history for half the branches
    for (int i = 0; i < 4000; i++) begin
      k  = int'($urandom_range(0, 7));
      pc = k * 4 + 'h40;
      if (k < 4) tk = ((m_hist & 1) ^ (k & 1));
      else       tk = (k == 7) ? 1 : ((i % 5) == 0 ? 0 : 1);
      if ($urandom_range(0, 15) == 0) tk = 1 - tk;
      cycle(int'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)) * 4 + 'h40,
            int'($urandom_range(0, 7) != 0), pc, tk);
    end

    // reset again mid-run restores R1 state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    cycle(1, 'h40, 0, 0, 0);
    check("R1", "pred_taken after second reset", last_pt, 0);
    check("R1", "sel_global after second reset", last_sel, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule